// File: doc/BRIEF.md
# Framing Byte Inserter with Burst Corruption

This block sits in the byte-wide transmit datapath of a byte-interleaved STS-12 stream. It takes one byte per clock and a frame-start strobe, and keeps its own count of the byte offset within the frame. While it is aligned to a frame, it overwrites the framing overhead with the fixed patterns: offsets 0 to NCH-1 become 0xF6 and offsets NCH to 2*NCH-1 become 0x28. Every other byte is forwarded unchanged.

For fault injection, a rising edge on the stream's error enable arms a corruption burst. The burst uses two shared substitute bytes and a shared frame count, all captured at arming. In each frame of the burst, only the last of the 0xF6 bytes and the first of the 0x28 bytes take the substitute values. A count of zero makes the burst run for as long as the enable stays high.

The burst is controlled by a four-state machine. The states are IDLE, ARMED, BURST and SPENT. The transitions are:
- IDLE→ARMED on a rising edge of the enable, which loads the count.
- ARMED→BURST at the next frame start.
- BURST→BURST at a frame start while frames remain or in endless mode, and the counter decrements.
- BURST→SPENT at a frame start once the count is used up.
- Any state→IDLE whenever the enable is low.

Top module: `frm_inserter`

## Requirements
- R1: While aligned, every byte at offsets 0 to NCH-1 leaves as 0xF6, except the offset NCH-1 byte of a corrupted frame.
- R2: While aligned, every byte at offsets NCH to 2*NCH-1 leaves as 0x28, except the offset NCH byte of a corrupted frame.
- R3: Bytes at offsets 2*NCH and above pass unchanged. Before the first frame start, every byte passes unchanged and the offset output reads 0.
- R4: Output data, frame-start strobe and byte offset appear one clock after the input byte. A frame start forces offset 0. Without a strobe, the offset counts up and wraps from FRAME_BYTES-1 to 0, and insertion continues.
- R5: A rising edge of the enable arms a burst, which begins with the first frame start after the edge cycle. In a corrupted frame, offset NCH-1 carries the substitute first value and offset NCH carries the substitute second value.
- R6: A burst with count N corrupts exactly N frames. After that, frames are clean while the enable stays high.
- R7: A count of zero corrupts every frame for as long as the enable stays high.
- R8: The substitute values and the count are sampled only at arming. Later changes on those inputs do not affect the running burst.
- R9: A byte presented while the enable is low is never corrupted. After the enable is cleared, only a new rising edge starts another burst.
- R10: During and right after reset, the data output, strobe and offset outputs are 0, and the controller is IDLE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sof_i | input | 1 | Frame start, high on the byte at offset 0 |
| data_i | input | 8 | Input byte |
| err_en_i | input | 1 | Per-stream corruption enable; a rising edge arms a burst |
| bad_a1_i | input | 8 | Shared substitute for the last 0xF6 byte |
| bad_a2_i | input | 8 | Shared substitute for the first 0x28 byte |
| bad_frames_i | input | CNT_W | Shared burst length in frames, 0 = endless |
| sof_o | output | 1 | Frame start, delayed to match data_o |
| data_o | output | 8 | Output byte |
| pos_o | output | $clog2(FRAME_BYTES) | Byte offset of data_o within the frame |

## Verification
The bench builds the block with NCH=3, FRAME_BYTES=24 and CNT_W=4. With these values a frame is short enough that a few dozen frames cover every edge case in under a thousand cycles. Those cases are: each overhead offset, offset wrap without a strobe, an early frame start, finite and endless bursts, a mid-frame enable drop, a configuration change during a burst, and re-arming.

// File: rtl/frm_pkg.sv
`timescale 1ns/1ps
package frm_pkg;
    typedef enum logic [1:0] {
        CS_IDLE  = 2'd0,
        CS_ARMED = 2'd1,
        CS_BURST = 2'd2,
        CS_SPENT = 2'd3
    } corrupt_state_e;
endpackage

// File: rtl/frm_pos_track.sv
`timescale 1ns/1ps
module frm_pos_track #(
    parameter int FRAME_BYTES = 9720,
    parameter int POS_W       = $clog2(FRAME_BYTES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sof_i,
    output logic [POS_W-1:0] cur_pos,
    output logic             aligned,
    output logic             aligned_q
);
    localparam logic [POS_W-1:0] LAST = POS_W'(FRAME_BYTES - 1);

    logic [POS_W-1:0] pos_q;

    // offset of the byte currently on data_i
    always_comb begin
        if (sof_i) begin
            cur_pos = '0;
            aligned = 1'b1;
        end else if (aligned_q) begin
            cur_pos = (pos_q == LAST) ? '0 : pos_q + POS_W'(1);
            aligned = 1'b1;
        end else begin
            cur_pos = '0;
            aligned = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pos_q     <= '0;
            aligned_q <= 1'b0;
        end else begin
            pos_q     <= cur_pos;
            aligned_q <= aligned;
        end
    end
endmodule

// File: rtl/frm_corrupt_ctl.sv
`timescale 1ns/1ps
module frm_corrupt_ctl
    import frm_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sof_i,
    input  logic             err_en_i,
    input  logic [7:0]       bad_a1_i,
    input  logic [7:0]       bad_a2_i,
    input  logic [CNT_W-1:0] bad_frames_i,
    output logic             corrupt_o,
    output logic [7:0]       bad_a1_o,
    output logic [7:0]       bad_a2_o,
    output corrupt_state_e   state_o
);
    corrupt_state_e   state_q, state_d;
    logic [CNT_W-1:0] rem_q, rem_d;
    logic             en_q;
    logic             endless_q;
    logic             rise;

    assign rise = err_en_i & ~en_q;

    // next-state logic
    always_comb begin
        state_d = state_q;
        rem_d   = rem_q;
        unique case (state_q)
            CS_IDLE: begin
                if (rise) begin
                    state_d = CS_ARMED;
                    rem_d   = bad_frames_i;
                end
            end
            CS_ARMED: begin
                if (sof_i) begin
                    state_d = CS_BURST;
                    if (!endless_q) rem_d = rem_q - CNT_W'(1);
                end
            end
            CS_BURST: begin
                if (sof_i && !endless_q) begin
                    if (rem_q == '0) state_d = CS_SPENT;
                    else             rem_d   = rem_q - CNT_W'(1);
                end
            end
            CS_SPENT: begin
                state_d = CS_SPENT;
            end
        endcase
        if (!err_en_i) state_d = CS_IDLE;
    end

    // state register and arming capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= CS_IDLE;
            rem_q     <= '0;
            en_q      <= 1'b0;
            endless_q <= 1'b0;
            bad_a1_o  <= '0;
            bad_a2_o  <= '0;
        end else begin
            state_q <= state_d;
            rem_q   <= rem_d;
            en_q    <= err_en_i;
            if (state_q == CS_IDLE && rise) begin
                endless_q <= (bad_frames_i == '0);
                bad_a1_o  <= bad_a1_i;
                bad_a2_o  <= bad_a2_i;
            end
        end
    end

    // outputs
    always_comb begin
        state_o   = state_q;
        corrupt_o = (state_q == CS_BURST) && err_en_i;
    end
endmodule

// File: rtl/frm_byte_mux.sv
`timescale 1ns/1ps
module frm_byte_mux #(
    parameter int         NCH    = 12,
    parameter int         POS_W  = 14,
    parameter logic [7:0] A1_PAT = 8'hF6,
    parameter logic [7:0] A2_PAT = 8'h28
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [7:0]       data_i,
    input  logic             sof_i,
    input  logic [POS_W-1:0] cur_pos,
    input  logic             aligned,
    input  logic             corrupt,
    input  logic [7:0]       bad_a1,
    input  logic [7:0]       bad_a2,
    output logic [7:0]       data_o,
    output logic             sof_o,
    output logic [POS_W-1:0] pos_o
);
    localparam logic [POS_W-1:0] A2_START = POS_W'(NCH);
    localparam logic [POS_W-1:0] A1_LAST  = POS_W'(NCH - 1);
    localparam logic [POS_W-1:0] OH_END   = POS_W'(2 * NCH);

    logic [7:0] byte_d;

    always_comb begin
        byte_d = data_i;
        if (aligned && cur_pos < A2_START) begin
            byte_d = (corrupt && cur_pos == A1_LAST) ? bad_a1 : A1_PAT;
        end else if (aligned && cur_pos < OH_END) begin
            byte_d = (corrupt && cur_pos == A2_START) ? bad_a2 : A2_PAT;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_o <= '0;
            sof_o  <= 1'b0;
            pos_o  <= '0;
        end else begin
            data_o <= byte_d;
            sof_o  <= sof_i;
            pos_o  <= cur_pos;
        end
    end
endmodule

// File: rtl/frm_inserter.sv
`timescale 1ns/1ps
module frm_inserter
    import frm_pkg::*;
#(
    parameter int         NCH         = 12,
    parameter int         FRAME_BYTES = 9720,
    parameter int         CNT_W       = 8,
    parameter logic [7:0] A1_PAT      = 8'hF6,
    parameter logic [7:0] A2_PAT      = 8'h28,
    localparam int        POS_W       = $clog2(FRAME_BYTES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sof_i,
    input  logic [7:0]       data_i,
    input  logic             err_en_i,
    input  logic [7:0]       bad_a1_i,
    input  logic [7:0]       bad_a2_i,
    input  logic [CNT_W-1:0] bad_frames_i,
    output logic             sof_o,
    output logic [7:0]       data_o,
    output logic [POS_W-1:0] pos_o
);
    logic [POS_W-1:0] cur_pos_w;
    logic             aligned_w;
    logic             aligned_q_w;
    logic             corrupt_w;
    logic [7:0]       cap_a1_w;
    logic [7:0]       cap_a2_w;
    corrupt_state_e   state_w;

    frm_pos_track #(
        .FRAME_BYTES(FRAME_BYTES),
        .POS_W      (POS_W)
    ) u_pos (
        .clk      (clk),
        .rst_n    (rst_n),
        .sof_i    (sof_i),
        .cur_pos  (cur_pos_w),
        .aligned  (aligned_w),
        .aligned_q(aligned_q_w)
    );

    frm_corrupt_ctl #(
        .CNT_W(CNT_W)
    ) u_ctl (
        .clk         (clk),
        .rst_n       (rst_n),
        .sof_i       (sof_i),
        .err_en_i    (err_en_i),
        .bad_a1_i    (bad_a1_i),
        .bad_a2_i    (bad_a2_i),
        .bad_frames_i(bad_frames_i),
        .corrupt_o   (corrupt_w),
        .bad_a1_o    (cap_a1_w),
        .bad_a2_o    (cap_a2_w),
        .state_o     (state_w)
    );

    frm_byte_mux #(
        .NCH   (NCH),
        .POS_W (POS_W),
        .A1_PAT(A1_PAT),
        .A2_PAT(A2_PAT)
    ) u_mux (
        .clk    (clk),
        .rst_n  (rst_n),
        .data_i (data_i),
        .sof_i  (sof_i),
        .cur_pos(cur_pos_w),
        .aligned(aligned_w),
        .corrupt(corrupt_w),
        .bad_a1 (cap_a1_w),
        .bad_a2 (cap_a2_w),
        .data_o (data_o),
        .sof_o  (sof_o),
        .pos_o  (pos_o)
    );
endmodule

// File: rtl/frm_inserter_chk.sv
`timescale 1ns/1ps
module frm_inserter_chk
    import frm_pkg::*;
#(
    parameter int         NCH         = 12,
    parameter int         FRAME_BYTES = 9720,
    parameter int         POS_W       = 14,
    parameter logic [7:0] A1_PAT      = 8'hF6,
    parameter logic [7:0] A2_PAT      = 8'h28
) (
    input logic             clk,
    input logic             rst_n,
    input logic             sof_i,
    input logic [7:0]       data_i,
    input logic             err_en_i,
    input logic             sof_o,
    input logic [7:0]       data_o,
    input logic [POS_W-1:0] pos_o,
    input logic             aligned_q,
    input logic             corrupt,
    input corrupt_state_e   state
);
    localparam logic [POS_W-1:0] LAST     = POS_W'(FRAME_BYTES - 1);
    localparam logic [POS_W-1:0] A1_LAST  = POS_W'(NCH - 1);
    localparam logic [POS_W-1:0] A2_START = POS_W'(NCH);
    localparam logic [POS_W-1:0] OH_END   = POS_W'(2 * NCH);

    a_r1_a1_fixed: assert property (@(posedge clk) disable iff (!rst_n)
        (aligned_q && pos_o < A1_LAST) |-> (data_o == A1_PAT));

    a_r2_a2_fixed: assert property (@(posedge clk) disable iff (!rst_n)
        (aligned_q && pos_o > A2_START && pos_o < OH_END) |-> (data_o == A2_PAT));

    a_r3_payload_pass: assert property (@(posedge clk) disable iff (!rst_n)
        (aligned_q && pos_o >= OH_END) |-> (data_o == $past(data_i)));

    a_r4_sof_zero: assert property (@(posedge clk) disable iff (!rst_n)
        sof_o |-> (pos_o == '0));

    a_r4_pos_step: assert property (@(posedge clk) disable iff (!rst_n)
        (aligned_q && !sof_i) |=>
        (pos_o == (($past(pos_o) == LAST) ? '0 : $past(pos_o) + POS_W'(1))));

    a_r5_bad_only_in_burst: assert property (@(posedge clk) disable iff (!rst_n)
        (aligned_q && pos_o == A1_LAST && data_o != A1_PAT) |-> $past(corrupt));

    a_r9_idle_when_low: assert property (@(posedge clk) disable iff (!rst_n)
        (!err_en_i) |=> (state == CS_IDLE));
endmodule

bind frm_inserter frm_inserter_chk #(
    .NCH        (NCH),
    .FRAME_BYTES(FRAME_BYTES),
    .POS_W      (POS_W),
    .A1_PAT     (A1_PAT),
    .A2_PAT     (A2_PAT)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .sof_i    (sof_i),
    .data_i   (data_i),
    .err_en_i (err_en_i),
    .sof_o    (sof_o),
    .data_o   (data_o),
    .pos_o    (pos_o),
    .aligned_q(aligned_q_w),
    .corrupt  (corrupt_w),
    .state    (state_w)
);

// File: tb/frm_inserter_test.sv
`timescale 1ns/1ps
module frm_inserter_test;
    localparam int NCH   = 3;
    localparam int FB    = 24;
    localparam int CNT_W = 4;
    localparam int POS_W = $clog2(FB);

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             sof_i = 1'b0;
    logic [7:0]       data_i = '0;
    logic             err_en_i = 1'b0;
    logic [7:0]       bad_a1_i = '0;
    logic [7:0]       bad_a2_i = '0;
    logic [CNT_W-1:0] bad_frames_i = '0;
    logic             sof_o;
    logic [7:0]       data_o;
    logic [POS_W-1:0] pos_o;

    int checks = 0;
    int errors = 0;
    int exp_pos = 0;
    int seed = 0;
    bit done = 1'b0;

    logic [7:0] qd[$];
    bit         qs[$];
    int         qp[$];
    string      qt[$];

    always #4 clk = ~clk;

    frm_inserter #(
        .NCH        (NCH),
        .FRAME_BYTES(FB),
        .CNT_W      (CNT_W)
    ) uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .sof_i       (sof_i),
        .data_i      (data_i),
        .err_en_i    (err_en_i),
        .bad_a1_i    (bad_a1_i),
        .bad_a2_i    (bad_a2_i),
        .bad_frames_i(bad_frames_i),
        .sof_o       (sof_o),
        .data_o      (data_o),
        .pos_o       (pos_o)
    );

    function automatic logic [7:0] model(int pos, logic [7:0] din, bit bad,
                                         logic [7:0] e1, logic [7:0] e2);
        if (pos < NCH)     return (bad && pos == NCH - 1) ? e1 : 8'hF6;
        if (pos < 2 * NCH) return (bad && pos == NCH) ? e2 : 8'h28;
        return din;
    endfunction

    // monitor: one result per driven byte, one clock later
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (qd.size() > 0) begin
                logic [7:0] ed;
                bit es;
                int ep;
                string et;
                ed = qd.pop_front();
                es = qs.pop_front();
                ep = qp.pop_front();
                et = qt.pop_front();
                checks++;
                if (data_o !== ed || sof_o !== es || int'(pos_o) != ep) begin
                    errors++;
                    $display("FAIL %s: data=%h sof=%b pos=%0d expected data=%h sof=%b pos=%0d",
                             et, data_o, sof_o, pos_o, ed, es, ep);
                end
            end
        end
    end

    // bytes before any frame start: pass through, offset 0
    task automatic send_raw(input int n, input string tag);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            sof_i  = 1'b0;
            data_i = 8'(seed * 29 + 7);
            seed++;
            qd.push_back(data_i); qs.push_back(1'b0); qp.push_back(0); qt.push_back(tag);
        end
    endtask

    task automatic send_frame(input int len, input bit with_sof, input bit bad,
                              input int en_idx, input bit en_val,
                              input logic [7:0] e1, input logic [7:0] e2,
                              input string tag);
        for (int i = 0; i < len; i++) begin
            @(negedge clk);
            sof_i = with_sof && (i == 0);
            if (sof_i) exp_pos = 0;
            else       exp_pos = (exp_pos == FB - 1) ? 0 : exp_pos + 1;
            data_i = 8'(seed * 29 + i * 13 + 5);
            seed++;
            if (i == en_idx) err_en_i = en_val;
            qd.push_back(model(exp_pos, data_i, bad && en_val | (bad && i != en_idx), e1, e2));
            qs.push_back(sof_i);
            qp.push_back(exp_pos);
            qt.push_back(tag);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        checks++;
        if (data_o !== 8'h00 || sof_o !== 1'b0 || pos_o !== '0) begin
            errors++;
            $display("FAIL R10: data=%h sof=%b pos=%0d expected data=00 sof=0 pos=0",
                     data_o, sof_o, pos_o);
        end
        rst_n = 1'b1;

        send_raw(5, "R3");
        send_frame(FB, 1, 0, -1, 0, 8'h00, 8'h00, "R1");
        bad_a1_i = 8'h11; bad_a2_i = 8'h22; bad_frames_i = 4'd2;
        send_frame(FB, 1, 0, FB - 2, 1, 8'h00, 8'h00, "R2");
        send_frame(FB, 1, 1, -1, 1, 8'h11, 8'h22, "R5");
        bad_a1_i = 8'h99; bad_a2_i = 8'hAA; bad_frames_i = 4'd5;
        send_frame(FB, 1, 1, -1, 1, 8'h11, 8'h22, "R8");
        send_frame(FB, 1, 0, -1, 1, 8'h00, 8'h00, "R6");
        send_frame(FB, 1, 0, FB - 2, 0, 8'h00, 8'h00, "R6");
        bad_a1_i = 8'h33; bad_a2_i = 8'h44; bad_frames_i = 4'd0;
        send_frame(FB, 1, 0, FB - 2, 1, 8'h00, 8'h00, "R7");
        send_frame(FB, 1, 1, -1, 1, 8'h33, 8'h44, "R7");
        send_frame(FB, 1, 1, -1, 1, 8'h33, 8'h44, "R7");
        send_frame(FB, 1, 1, FB - 2, 0, 8'h33, 8'h44, "R7");
        bad_a1_i = 8'h55; bad_a2_i = 8'h66; bad_frames_i = 4'd3;
        send_frame(FB, 1, 0, FB - 2, 1, 8'h00, 8'h00, "R9");
        send_frame(FB, 1, 1, -1, 1, 8'h55, 8'h66, "R9");
        send_frame(FB, 1, 0, 1, 0, 8'h00, 8'h00, "R9");
        bad_a1_i = 8'h77; bad_a2_i = 8'h88; bad_frames_i = 4'd1;
        send_frame(FB, 1, 0, FB - 2, 1, 8'h00, 8'h00, "R9");
        send_frame(FB, 1, 1, -1, 1, 8'h77, 8'h88, "R5");
        send_frame(FB, 1, 0, -1, 1, 8'h00, 8'h00, "R6");
        send_frame(10, 1, 0, -1, 1, 8'h00, 8'h00, "R4");
        send_frame(FB, 1, 0, -1, 1, 8'h00, 8'h00, "R4");
        send_frame(FB, 0, 0, -1, 1, 8'h00, 8'h00, "R4");
        send_frame(FB, 1, 0, -1, 1, 8'h00, 8'h00, "R4");

        repeat (3) @(negedge clk);
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        #(8 * 200000);
        if (!done) begin
            done = 1'b1;
            errors++;
            checks++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule